// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Takeover

This block sits between a bank of timer channels and the interrupt fabric. Each timer channel raises a one-cycle match event. The router keeps a status bit for every channel, and software clears a bit by writing 1 to it. For each channel the router either drives an interrupt line or issues a message write. A line can follow the status bit (level type) or carry a one-cycle pulse (edge type). A message write carries a 32-bit address and 32-bit data taken from that channel's 64-bit message word. Line numbers 16 and above are active-low. The logic folds this inversion in, so the rest of the design always works in active-high terms.

A global legacy takeover mode pins channel 0 to line 0 and channel 1 to line 8. In the same mode it blocks the external PIT and RTC interrupt inputs from reaching those lines and drops a PIT-enable output. The RTC input is registered on every cycle. When legacy mode ends, line 8 takes the last registered RTC level at once. Counting and comparison are done elsewhere. This block only sees the match events and the configuration.

Top module: `irq_router`

## Requirements
- R1: During and after reset, `irq_status` is zero, `msg_valid` is low and `pit_enable` is high. Every line below 16 is low and every line 16 and above is high. The registered PIT and RTC levels are zero.
- R2: A match on a channel with `ch_enable` set, while `glb_enable` is high, sets that channel's status bit at the next clock edge. This holds for both level and edge channels.
- R3: When `sts_clr_valid` is high, each bit written as 1 in `sts_clr_mask` clears the matching status bit. Bits written as 0 keep their value. A qualified match in the same cycle wins, and that bit is left set.
- R4: A level channel (`ch_level`=1) holds its line active for as long as its status bit is set. The line is inactive again two clocks after the clear write.
- R5: An edge channel (`ch_level`=0) makes its line active for exactly one cycle per match. That cycle starts two clock edges after the match is sampled.
- R6: Active means high on lines 0 to 15, and low on lines 16 to NUM_LINES-1.
- R7: Outside legacy mode, a channel drives the line whose index is its `ch_route` field. A route value of NUM_LINES or more drives no line.
- R8: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. All other channels keep using their route fields.
- R9: A channel with `ch_msg_en` set drives no line. Each qualified match produces one `msg_valid` cycle two edges later. `msg_addr` then carries bits 63:32 of the channel's message word, and `msg_data` carries bits 31:0. Setting `ch_msg_en` on a channel whose line is active makes that line inactive one edge later.
- R10: When several message requests are pending, one is sent per cycle, lowest channel index first, and none is lost.
- R11: `pit_enable` is the registered inverse of `glb_legacy`. Outside legacy mode, line 0 shows the registered `pit_irq_in` and line 8 shows the registered `rtc_irq_in`. In legacy mode neither input reaches a line. The RTC level is registered even while legacy mode is on, so on exit line 8 takes that level.
- R12: A disabled channel, or any channel while `glb_enable` is low, sets no status bit, drives no line and sends no message. A status bit that is already set gets its line back once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_match | input | NUM_CH | One-cycle match event per channel |
| ch_enable | input | NUM_CH | Per-channel interrupt enable |
| ch_level | input | NUM_CH | 1 = level type, 0 = edge type |
| ch_msg_en | input | NUM_CH | Deliver by message write instead of a line |
| ch_route | input | NUM_CH*ROUTE_W | Line index per channel, channel c at bits c*ROUTE_W upward |
| ch_msg_word | input | NUM_CH*64 | Per channel: address in bits 63:32, data in bits 31:0 |
| glb_enable | input | 1 | Global interrupt enable |
| glb_legacy | input | 1 | Legacy takeover mode |
| pit_irq_in | input | 1 | External PIT interrupt level |
| rtc_irq_in | input | 1 | External RTC interrupt level |
| sts_clr_valid | input | 1 | Status write strobe |
| sts_clr_mask | input | NUM_CH | Write-1-to-clear data |
| irq_lines | output | NUM_LINES | Interrupt lines at their physical polarity |
| irq_status | output | NUM_CH | Channel status register |
| pit_enable | output | 1 | High while legacy mode is off |
| msg_valid | output | 1 | Message write request, one cycle per message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bound checker watches these relations on every cycle:
- A qualified match sets its status bit, and no status bit is set while the block is disabled.
- A clear write empties the masked status bits when no match competes with it.
- `pit_enable` follows the legacy bit.
- While the block is disabled in legacy mode, the lines stay in their idle pattern.

Other behaviour depends on routes, types and history, so only the bench scenarios show it. This covers where each route lands and at which polarity, the exact cycle of an edge pulse, the legacy pinning of channels 0 and 1, the RTC level restored on exit, and message contents with their lowest-index-first order. The bench sweeps every route value, plus two out-of-range values, on every channel, in both types.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int PIT_LINE = 0;
    localparam int RTC_LINE = 8;
    localparam int INV_BASE = 16;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } msg_t;

    // Line a channel drives, given legacy mode and its route field.
    function automatic int target_line(int ch, int route, logic legacy);
        if (legacy && ch == 0) return PIT_LINE;
        if (legacy && ch == 1) return RTC_LINE;
        return route;
    endfunction

    function automatic logic line_inverted(int idx);
        return idx >= INV_BASE;
    endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt_in,
    input  logic              clr_valid,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] status_q,
    output logic [NUM_CH-1:0] evt_q
);
    logic [NUM_CH-1:0] clr_bits;
    logic [NUM_CH-1:0] status_d;

    // A new event in the same cycle as a clear keeps the bit set.
    always_comb begin
        clr_bits = clr_valid ? clr_mask : '0;
        status_d = (status_q & ~clr_bits) | evt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            evt_q    <= '0;
        end else begin
            status_q <= status_d;
            evt_q    <= evt_in;
        end
    end
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_router_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [NUM_CH-1:0] req,
    input  logic [63:0]       words [NUM_CH],
    output logic              out_valid,
    output msg_t              out_msg
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] grant;
    logic [63:0]       sel;

    // Lowest pending index wins; one message leaves per cycle.
    always_comb begin
        grant = pend_q & (~pend_q + NUM_CH'(1));
        sel   = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (grant[c]) sel = sel | words[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            pend_q    <= flush ? '0 : ((pend_q & ~grant) | req);
            out_valid <= (|grant) & ~flush;
            out_msg   <= sel;
        end
    end
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_router_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24,
    parameter int ROUTE_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    status_q,
    input  logic [NUM_CH-1:0]    evt_q,
    input  logic [NUM_CH-1:0]    ch_enable,
    input  logic [NUM_CH-1:0]    ch_level,
    input  logic [NUM_CH-1:0]    ch_msg_en,
    input  logic [ROUTE_W-1:0]   routes [NUM_CH],
    input  logic                 glb_enable,
    input  logic                 glb_legacy,
    input  logic                 pit_in,
    input  logic                 rtc_in,
    output logic [NUM_LINES-1:0] lines_q,
    output logic                 pit_enable_q
);
    function automatic logic [NUM_LINES-1:0] make_inv_mask();
        logic [NUM_LINES-1:0] m;
        for (int i = 0; i < NUM_LINES; i++) m[i] = line_inverted(i);
        return m;
    endfunction

    localparam logic [NUM_LINES-1:0] INV_MASK = make_inv_mask();

    logic                 pit_q;
    logic                 rtc_q;
    logic [NUM_CH-1:0]    drive;
    int                   tgt [NUM_CH];
    logic [NUM_LINES-1:0] logical;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            drive[c] = (ch_level[c] ? status_q[c] : evt_q[c])
                       & ch_enable[c] & glb_enable & ~ch_msg_en[c];
            tgt[c]   = target_line(c, int'(routes[c]), glb_legacy);
        end
        logical = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (drive[c] && tgt[c] == l) logical[l] = 1'b1;
            end
            if (l == PIT_LINE && !glb_legacy && pit_q) logical[l] = 1'b1;
            if (l == RTC_LINE && !glb_legacy && rtc_q) logical[l] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pit_q        <= 1'b0;
            rtc_q        <= 1'b0;
            lines_q      <= INV_MASK;
            pit_enable_q <= 1'b1;
        end else begin
            pit_q        <= pit_in;
            rtc_q        <= rtc_in;
            lines_q      <= logical ^ INV_MASK;
            pit_enable_q <= ~glb_legacy;
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24,
    parameter int ROUTE_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH-1:0]         ch_match,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic [NUM_CH-1:0]         ch_level,
    input  logic [NUM_CH-1:0]         ch_msg_en,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic [NUM_CH*64-1:0]      ch_msg_word,
    input  logic                      glb_enable,
    input  logic                      glb_legacy,
    input  logic                      pit_irq_in,
    input  logic                      rtc_irq_in,
    input  logic                      sts_clr_valid,
    input  logic [NUM_CH-1:0]         sts_clr_mask,
    output logic [NUM_LINES-1:0]      irq_lines,
    output logic [NUM_CH-1:0]         irq_status,
    output logic                      pit_enable,
    output logic                      msg_valid,
    output logic [31:0]               msg_addr,
    output logic [31:0]               msg_data
);
    logic [ROUTE_W-1:0] routes [NUM_CH];
    logic [63:0]        words  [NUM_CH];
    logic [NUM_CH-1:0]  qual_evt;
    logic [NUM_CH-1:0]  evt_q;
    msg_t               msg_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_split
        assign routes[g] = ch_route[g*ROUTE_W +: ROUTE_W];
        assign words[g]  = ch_msg_word[g*64 +: 64];
    end

    assign qual_evt = ch_match & ch_enable & {NUM_CH{glb_enable}};

    irq_status_reg #(.NUM_CH(NUM_CH)) u_status (
        .clk       (clk),
        .rst       (rst),
        .evt_in    (qual_evt),
        .clr_valid (sts_clr_valid),
        .clr_mask  (sts_clr_mask),
        .status_q  (irq_status),
        .evt_q     (evt_q)
    );

    irq_msg_arb #(.NUM_CH(NUM_CH)) u_msg (
        .clk       (clk),
        .rst       (rst),
        .flush     (~glb_enable),
        .req       (qual_evt & ch_msg_en),
        .words     (words),
        .out_valid (msg_valid),
        .out_msg   (msg_q)
    );

    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

    irq_line_map #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES),
        .ROUTE_W   (ROUTE_W)
    ) u_lines (
        .clk          (clk),
        .rst          (rst),
        .status_q     (irq_status),
        .evt_q        (evt_q),
        .ch_enable    (ch_enable),
        .ch_level     (ch_level),
        .ch_msg_en    (ch_msg_en),
        .routes       (routes),
        .glb_enable   (glb_enable),
        .glb_legacy   (glb_legacy),
        .pit_in       (pit_irq_in),
        .rtc_in       (rtc_irq_in),
        .lines_q      (irq_lines),
        .pit_enable_q (pit_enable)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_CH-1:0]    ch_match,
    input logic [NUM_CH-1:0]    ch_enable,
    input logic                 glb_enable,
    input logic                 glb_legacy,
    input logic                 sts_clr_valid,
    input logic [NUM_CH-1:0]    sts_clr_mask,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [NUM_CH-1:0]    irq_status,
    input logic                 pit_enable
);
    function automatic logic [NUM_LINES-1:0] idle_pattern();
        logic [NUM_LINES-1:0] m;
        for (int i = 0; i < NUM_LINES; i++) m[i] = (i >= INV_BASE);
        return m;
    endfunction

    localparam logic [NUM_LINES-1:0] IDLE = idle_pattern();

    logic [1:0]        warm_cnt;
    logic              warm;
    logic [NUM_CH-1:0] qual;

    always_ff @(posedge clk) begin
        if (rst) warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end

    assign warm = (warm_cnt == 2'd3);
    assign qual = ch_match & ch_enable & {NUM_CH{glb_enable}};

    p_set_on_event_r2: assert property (@(posedge clk) disable iff (rst)
        (|qual) |=> ((irq_status & $past(qual)) == $past(qual)));

    p_no_set_when_off_r12: assert property (@(posedge clk) disable iff (rst)
        !glb_enable |=> ((irq_status & ~$past(irq_status)) == '0));

    p_clear_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (sts_clr_valid && !(|ch_match)) |=> ((irq_status & $past(sts_clr_mask)) == '0));

    p_pit_enable_r11: assert property (@(posedge clk) disable iff (rst)
        warm |-> (pit_enable == !$past(glb_legacy)));

    p_quiet_legacy_r12: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(glb_enable) && !$past(glb_enable, 2)
         && $past(glb_legacy) && $past(glb_legacy, 2)) |-> (irq_lines == IDLE));
endmodule

bind irq_router irq_router_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ch_match      (ch_match),
    .ch_enable     (ch_enable),
    .glb_enable    (glb_enable),
    .glb_legacy    (glb_legacy),
    .sts_clr_valid (sts_clr_valid),
    .sts_clr_mask  (sts_clr_mask),
    .irq_lines     (irq_lines),
    .irq_status    (irq_status),
    .pit_enable    (pit_enable)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NL  = 24;
    localparam int RW  = 5;
    localparam logic [NL-1:0] IDLE = 24'hFF0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    ch_match = '0, ch_enable = '0, ch_level = '0, ch_msg_en = '0;
    logic [NCH*RW-1:0] ch_route = '0;
    logic [NCH*64-1:0] ch_msg_word = '0;
    logic              glb_enable = 1'b0, glb_legacy = 1'b0;
    logic              pit_irq_in = 1'b0, rtc_irq_in = 1'b0;
    logic              sts_clr_valid = 1'b0;
    logic [NCH-1:0]    sts_clr_mask = '0;
    logic [NL-1:0]     irq_lines;
    logic [NCH-1:0]    irq_status;
    logic              pit_enable, msg_valid;
    logic [31:0]       msg_addr, msg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_CH(NCH), .NUM_LINES(NL), .ROUTE_W(RW)) dut_i (
        .clk(clk), .rst(rst), .ch_match(ch_match), .ch_enable(ch_enable),
        .ch_level(ch_level), .ch_msg_en(ch_msg_en), .ch_route(ch_route),
        .ch_msg_word(ch_msg_word), .glb_enable(glb_enable), .glb_legacy(glb_legacy),
        .pit_irq_in(pit_irq_in), .rtc_irq_in(rtc_irq_in),
        .sts_clr_valid(sts_clr_valid), .sts_clr_mask(sts_clr_mask),
        .irq_lines(irq_lines), .irq_status(irq_status), .pit_enable(pit_enable),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NL-1:0] with_lines(int a, int b, int c);
        logic [NL-1:0] v = IDLE;
        if (a >= 0 && a < NL) v[a] = ~v[a];
        if (b >= 0 && b < NL) v[b] = ~v[b];
        if (c >= 0 && c < NL) v[c] = ~v[c];
        return v;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cfg();
        ch_match = '0; ch_enable = '0; ch_level = '0; ch_msg_en = '0;
        ch_route = '0; ch_msg_word = '0; sts_clr_valid = 1'b0; sts_clr_mask = '0;
    endtask

    task automatic clear_all();
        sts_clr_valid = 1'b1; sts_clr_mask = '1;
        step(1);
        sts_clr_valid = 1'b0; sts_clr_mask = '0;
        step(3);
    endtask

    task automatic fire(logic [NCH-1:0] m);
        ch_match = m;
        step(1);
        ch_match = '0;
    endtask

    initial begin
        step(4);
        // R1: reset state
        check("R1 lines", 64'(irq_lines), 64'(IDLE));
        check("R1 status", 64'(irq_status), 64'd0);
        check("R1 pit_enable", 64'(pit_enable), 64'd1);
        check("R1 msg_valid", 64'(msg_valid), 64'd0);
        rst = 1'b0;
        step(2);
        check("R1 lines after release", 64'(irq_lines), 64'(IDLE));
        glb_enable = 1'b1;
        step(2);

        // R2 R4 R5 R6 R7: sweep every channel, route and type
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < NL + 2; r++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    clear_cfg();
                    ch_enable[c] = 1'b1;
                    ch_level[c]  = lvl[0];
                    ch_route[c*RW +: RW] = RW'(r);
                    fire(NCH'(1) << c);
                    check("R2 status set", 64'(irq_status), 64'(NCH'(1) << c));
                    step(1);
                    check(lvl ? "R4 R6 R7 level on" : "R5 R6 R7 pulse on",
                          64'(irq_lines), 64'(with_lines(r, -1, -1)));
                    step(1);
                    check(lvl ? "R4 level held" : "R5 pulse gone",
                          64'(irq_lines), 64'(lvl ? with_lines(r, -1, -1) : IDLE));
                    sts_clr_valid = 1'b1; sts_clr_mask = NCH'(1) << c;
                    step(1);
                    sts_clr_valid = 1'b0; sts_clr_mask = '0;
                    check("R3 cleared", 64'(irq_status), 64'd0);
                    step(1);
                    check("R4 line released", 64'(irq_lines), 64'(IDLE));
                end
            end
        end

        // R3: masked clear and event-wins-over-clear
        clear_cfg();
        ch_enable = 4'b0111; ch_route = {5'd0, 5'd20, 5'd21, 5'd20};
        fire(4'b0101);
        check("R3 set two", 64'(irq_status), 64'h5);
        sts_clr_valid = 1'b1; sts_clr_mask = 4'b0001;
        step(1);
        check("R3 masked clear", 64'(irq_status), 64'h4);
        sts_clr_mask = 4'b0110; ch_match = 4'b0010;
        step(1);
        sts_clr_valid = 1'b0; sts_clr_mask = '0; ch_match = '0;
        check("R3 event wins", 64'(irq_status), 64'h2);
        clear_all();

        // R8: legacy pinning of channels 0 and 1
        clear_cfg();
        ch_enable = 4'b0111; ch_level = 4'b0111;
        ch_route = {5'd0, 5'd3, 5'd6, 5'd5};
        glb_legacy = 1'b1;
        step(2);
        fire(4'b0111);
        step(1);
        check("R8 legacy lines", 64'(irq_lines), 64'(with_lines(0, 8, 3)));
        check("R11 pit_enable low", 64'(pit_enable), 64'd0);
        glb_legacy = 1'b0;
        step(2);
        check("R7 routed lines", 64'(irq_lines), 64'(with_lines(5, 6, 3)));
        clear_all();

        // R11: external sources and legacy gating
        clear_cfg();
        pit_irq_in = 1'b1; rtc_irq_in = 1'b1;
        step(3);
        check("R11 pass-through", 64'(irq_lines), 64'(with_lines(0, 8, -1)));
        check("R11 pit_enable high", 64'(pit_enable), 64'd1);
        glb_legacy = 1'b1;
        step(2);
        check("R11 gated", 64'(irq_lines), 64'(IDLE));
        check("R11 pit_enable dropped", 64'(pit_enable), 64'd0);
        rtc_irq_in = 1'b0;
        step(2);
        pit_irq_in = 1'b0; rtc_irq_in = 1'b1;
        step(3);
        check("R11 still gated", 64'(irq_lines), 64'(IDLE));
        glb_legacy = 1'b0;
        step(2);
        check("R11 rtc restored", 64'(irq_lines), 64'(with_lines(8, -1, -1)));
        check("R11 pit_enable back", 64'(pit_enable), 64'd1);
        rtc_irq_in = 1'b0;
        step(3);

        // R12: disabled block or channel
        clear_cfg();
        ch_enable = 4'b0001; ch_level = 4'b0001; ch_route[4:0] = 5'd2;
        glb_enable = 1'b0;
        step(1);
        fire(4'b0001);
        step(1);
        check("R12 block off status", 64'(irq_status), 64'd0);
        check("R12 block off lines", 64'(irq_lines), 64'(IDLE));
        glb_enable = 1'b1; ch_enable = '0; ch_msg_en = 4'b0001;
        fire(4'b0001);
        step(1);
        check("R12 channel off status", 64'(irq_status), 64'd0);
        check("R12 channel off msg", 64'(msg_valid), 64'd0);
        ch_enable = 4'b0001; ch_msg_en = '0;
        fire(4'b0001);
        step(1);
        check("R4 level on before gate", 64'(irq_lines), 64'(with_lines(2, -1, -1)));
        glb_enable = 1'b0;
        step(2);
        check("R12 gated by block off", 64'(irq_lines), 64'(IDLE));
        glb_enable = 1'b1;
        step(2);
        check("R12 returns with enable", 64'(irq_lines), 64'(with_lines(2, -1, -1)));
        ch_msg_en = 4'b0001;
        step(2);
        check("R9 message mode drops line", 64'(irq_lines), 64'(IDLE));
        clear_all();

        // R9: single message contents
        clear_cfg();
        ch_enable[2] = 1'b1; ch_level[2] = 1'b1; ch_msg_en[2] = 1'b1;
        ch_route[2*RW +: RW] = 5'd4;
        ch_msg_word[2*64 +: 64] = {32'hFEE0_1000, 32'h0000_0041};
        fire(4'b0100);
        check("R9 not yet", 64'(msg_valid), 64'd0);
        step(1);
        check("R9 valid", 64'(msg_valid), 64'd1);
        check("R9 addr", 64'(msg_addr), 64'hFEE0_1000);
        check("R9 data", 64'(msg_data), 64'h0000_0041);
        check("R9 no line", 64'(irq_lines), 64'(IDLE));
        step(1);
        check("R9 one cycle", 64'(msg_valid), 64'd0);
        clear_all();

        // R10: two simultaneous messages, lowest index first
        clear_cfg();
        ch_enable = 4'b1010; ch_msg_en = 4'b1010;
        ch_msg_word[1*64 +: 64] = {32'h1111_0000, 32'h0000_00A1};
        ch_msg_word[3*64 +: 64] = {32'h3333_0000, 32'h0000_00A3};
        fire(4'b1010);
        step(1);
        check("R10 first valid", 64'(msg_valid), 64'd1);
        check("R10 first is ch1", 64'({msg_addr, msg_data}), {32'h1111_0000, 32'h0000_00A1});
        step(1);
        check("R10 second valid", 64'(msg_valid), 64'd1);
        check("R10 second is ch3", 64'({msg_addr, msg_data}), {32'h3333_0000, 32'h0000_00A3});
        step(1);
        check("R10 drained", 64'(msg_valid), 64'd0);
        clear_all();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule